// File: doc/BRIEF.md
# Trigger-Centred Capture Store

This block holds `{timestamp, sample}` records in on-chip RAM so that a host can see what happened both before and after a trigger. After an arm pulse it fills a pre-trigger region. The size of that region is set by a ratio code, and the region works as a ring: the newest records overwrite the oldest ones. When the trigger flag arrives, capture changes to a straight fill of the memory that remains. When the last location has been written, the block raises a done flag and stops accepting writes.

A controller then pulls the records out one request at a time. The first record returned is the oldest pre-trigger record that survived. The readout walks once around the ring and then continues through the post-trigger records. The block also outputs the readout index of the first post-trigger record, so that the host can mark the trigger point on its time axis. A new arm pulse clears all pointers and the done flag, and capture starts again.

Top module: `capture_buffer`

## Requirements
- R1: After reset, `done_o`, `rd_valid_o` and `trig_idx_o` are 0. Write requests and triggers that arrive before the first arm pulse store nothing.
- R2: Each record is `{ts_i, sample_i}`, with the timestamp in the upper TS_W bits. Every record returned by readout equals the record as it was written.
- R3: The ratio code sampled at arm sets the pre-trigger depth PD to floor(code*DEPTH/10). A code of 0 is treated as 1, and a code above 9 is treated as 9. With DEPTH=64, codes 3, 5 and 9 give PD values of 19, 32 and 57.
- R4: Before the trigger, every write request stores one record into the ring of PD entries. Once more than PD records have been written, only the newest PD remain, and readout starts with the oldest of them.
- R5: If the trigger comes before PD records have been written, the pre-trigger part of the readout holds exactly the records that were written, oldest first. This part may be empty.
- R6: A write request in the same cycle as the trigger is the first post-trigger record. After DEPTH-PD post-trigger records, `done_o` rises in the cycle that follows the last write. It does not rise earlier.
- R7: While done, `trig_idx_o` equals the number of pre-trigger records that come before the first post-trigger record in readout order. It does not change until the next arm.
- R8: Write requests and triggers that arrive while done change neither the stored records nor `trig_idx_o`, and `done_o` stays high.
- R9: While done, each read request cycle gives `rd_valid_o` one cycle later, with the next record in order on `rd_data_o`. Once all records have been read, further requests give no `rd_valid_o`.
- R10: An arm pulse clears `done_o` and the readout position in the following cycle. Read requests made before done give no `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Clears pointers and starts a pre-trigger capture |
| ratio_i | input | 4 | Pre-trigger ratio code in tenths, sampled at arm |
| wr_req_i | input | 1 | Store one record (event or timestamp rollover) |
| ts_i | input | TS_W | Record timestamp |
| sample_i | input | DATA_W | Record channel sample |
| trig_i | input | 1 | Trigger condition met |
| rd_req_i | input | 1 | Request the next record during readout |
| rd_data_o | output | TS_W+DATA_W | Record read out, `{ts, sample}` |
| rd_valid_o | output | 1 | `rd_data_o` holds a new record |
| done_o | output | 1 | Memory full, capture finished |
| trig_idx_o | output | $clog2(DEPTH+1) | Readout index of the first post-trigger record |

## Verification
The assertions assume that `arm_i` is a single-cycle pulse and that `rd_valid_o` answers only requests made while done. They also assume that DEPTH is at least 10, so that PD is never zero. The stimulus sets `arm_i` high for one cycle only, and it drives inputs one time unit after the rising edge. It tries ratio codes inside and outside 1..9, triggers before the ring has filled, after it has wrapped, and with no pre-trigger records at all, and places writes in the trigger cycle and after done. A scoreboard compares the readout against a queue built from the requirements.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/capbuf_ram.sv
module capbuf_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/capbuf_wr_ctrl.sv
module capbuf_wr_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [3:0]    ratio_i,
  input  logic          wr_req_i,
  input  logic          trig_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] pre_depth_o,
  output logic [CW-1:0] pre_fill_o,
  output logic [AW-1:0] ring_head_o,
  output logic          done_o
);
  cap_state_e    state_q;
  logic [AW-1:0] ring_ptr_q, post_ptr_q, cur_post;
  logic [CW-1:0] pre_fill_q, pd_q, pd_calc;
  logic [3:0]    code_c;
  logic          post_mode, ring_wrap, post_last;

  always_comb begin
    if (ratio_i == 4'd0)      code_c = 4'd1;
    else if (ratio_i > 4'd9)  code_c = 4'd9;
    else                      code_c = ratio_i;
  end

  assign pd_calc   = CW'((32'(code_c) * DEPTH) / 10);
  assign post_mode = (state_q == ST_POST) || (state_q == ST_PRE && trig_i);
  assign cur_post  = (state_q == ST_POST) ? post_ptr_q : AW'(pd_q);
  assign post_last = (cur_post == AW'(DEPTH - 1));
  assign ring_wrap = (CW'(ring_ptr_q) + CW'(1)) == pd_q;

  assign we_o    = wr_req_i && !arm_i && (state_q == ST_PRE || state_q == ST_POST);
  assign waddr_o = post_mode ? cur_post : ring_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ring_ptr_q <= '0;
      post_ptr_q <= '0;
      pre_fill_q <= '0;
      pd_q       <= '0;
    end else if (arm_i) begin
      state_q    <= ST_PRE;
      ring_ptr_q <= '0;
      post_ptr_q <= '0;
      pre_fill_q <= '0;
      pd_q       <= pd_calc;
    end else begin
      unique case (state_q)
        ST_PRE: begin
          if (trig_i) begin
            state_q    <= ST_POST;
            post_ptr_q <= cur_post;
            if (wr_req_i) begin
              if (post_last) state_q <= ST_DONE;
              else           post_ptr_q <= cur_post + AW'(1);
            end
          end else if (wr_req_i) begin
            ring_ptr_q <= ring_wrap ? '0 : ring_ptr_q + AW'(1);
            if (pre_fill_q < pd_q) pre_fill_q <= pre_fill_q + CW'(1);
          end
        end
        ST_POST: begin
          if (wr_req_i) begin
            if (post_last) state_q <= ST_DONE;
            else           post_ptr_q <= post_ptr_q + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign pre_depth_o = pd_q;
  assign pre_fill_o  = pre_fill_q;
  assign ring_head_o = ring_ptr_q;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/capbuf_rd_seq.sv
module capbuf_rd_seq #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int XW   = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          done_i,
  input  logic          rd_req_i,
  input  logic [CW-1:0] pre_depth_i,
  input  logic [CW-1:0] pre_fill_i,
  input  logic [AW-1:0] ring_head_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_valid_o
);
  logic [CW-1:0] rd_cnt_q;
  logic [XW-1:0] total, pre_start, ring_sum, ring_addr, post_addr;
  logic          in_pre;

  assign total     = XW'(pre_fill_i) + XW'(DEPTH) - XW'(pre_depth_i);
  assign re_o      = rd_req_i && done_i && !arm_i && (XW'(rd_cnt_q) < total);
  // oldest survivor sits at the write head only once the ring has filled
  assign pre_start = (pre_fill_i == pre_depth_i) ? XW'(ring_head_i) : '0;
  assign ring_sum  = pre_start + XW'(rd_cnt_q);
  assign ring_addr = (ring_sum >= XW'(pre_depth_i)) ? ring_sum - XW'(pre_depth_i) : ring_sum;
  assign post_addr = XW'(pre_depth_i) + XW'(rd_cnt_q) - XW'(pre_fill_i);
  assign in_pre    = rd_cnt_q < pre_fill_i;
  assign raddr_o   = in_pre ? AW'(ring_addr) : AW'(post_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q   <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= re_o;
      if (arm_i)     rd_cnt_q <= '0;
      else if (re_o) rd_cnt_q <= rd_cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer #(
  parameter int TS_W   = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int REC_W = TS_W + DATA_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [3:0]        ratio_i,
  input  logic              wr_req_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              trig_i,
  input  logic              rd_req_i,
  output logic [REC_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic [CW-1:0]     trig_idx_o
);
  logic          we, re;
  logic [AW-1:0] waddr, raddr, ring_head;
  logic [CW-1:0] pre_depth, pre_fill;

  capbuf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .ratio_i    (ratio_i),
    .wr_req_i   (wr_req_i),
    .trig_i     (trig_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .pre_depth_o(pre_depth),
    .pre_fill_o (pre_fill),
    .ring_head_o(ring_head),
    .done_o     (done_o)
  );

  capbuf_rd_seq #(.DEPTH(DEPTH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .done_i     (done_o),
    .rd_req_i   (rd_req_i),
    .pre_depth_i(pre_depth),
    .pre_fill_i (pre_fill),
    .ring_head_i(ring_head),
    .re_o       (re),
    .raddr_o    (raddr),
    .rd_valid_o (rd_valid_o)
  );

  capbuf_ram #(.W(REC_W), .DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i({ts_i, sample_i}),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  assign trig_idx_o = pre_fill;
endmodule

// File: rtl/capture_buffer_chk.sv
module capture_buffer_chk #(
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          rd_req_i,
  input logic          rd_valid_o,
  input logic          done_o,
  input logic [CW-1:0] trig_idx_o
);
  AST_VALID_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> done_o); // R9
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !arm_i |=> done_o); // R8
  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !done_o && !rd_valid_o); // R10
  AST_IDX_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !arm_i |=> $stable(trig_idx_o)); // R7
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_idx_o < CW'(DEPTH)); // R5
endmodule

bind capture_buffer capture_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .rd_req_i  (rd_req_i),
  .rd_valid_o(rd_valid_o),
  .done_o    (done_o),
  .trig_idx_o(trig_idx_o)
);

// File: tb/tb_capture_buffer.sv
module tb_capture_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_ni = 0, arm = 0, wr_req = 0, trig = 0, rd_req = 0;
  logic [3:0] ratio = 0;
  logic [7:0] ts = 0, smp = 0;
  logic [15:0] rd_data;
  logic rd_valid, done;
  logic [CW-1:0] trig_idx;

  int checks = 0, fails = 0;
  int m_pd, m_state;
  logic [15:0] pre_hist[$], post_q[$], exp_q[$];
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_buffer dut (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm), .ratio_i(ratio), .wr_req_i(wr_req),
    .ts_i(ts), .sample_i(smp), .trig_i(trig), .rd_req_i(rd_req),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done), .trig_idx_o(trig_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pop scoreboard on every valid record
  always @(negedge clk) begin
    if (rst_ni && rd_valid) begin
      if (exp_q.size() == 0) chk(0, {tag, " unexpected record"}, int'(rd_data), -1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data === e, tag, int'(rd_data), int'(e));
      end
    end
  end

  task automatic do_arm(input logic [3:0] code);
    int c;
    c = (code == 0) ? 1 : (code > 9) ? 9 : int'(code);
    @(posedge clk); #1 arm = 1; ratio = code;
    @(posedge clk); #1 arm = 0;
    m_pd = c * DEPTH / 10; m_state = 1;
    pre_hist.delete(); post_q.delete(); exp_q.delete();
  endtask

  task automatic wr(input logic [15:0] rec, input bit t);
    @(posedge clk); #1 wr_req = 1; trig = t; {ts, smp} = rec;
    @(posedge clk); #1 wr_req = 0; trig = 0;
    if (m_state == 1 && t) m_state = 2;
    if (m_state == 1) begin
      pre_hist.push_back(rec);
      if (pre_hist.size() > m_pd) void'(pre_hist.pop_front());
    end else if (m_state == 2) begin
      post_q.push_back(rec);
      if (post_q.size() == DEPTH - m_pd) m_state = 3;
    end
  endtask

  task automatic trig_only();
    @(posedge clk); #1 trig = 1;
    @(posedge clk); #1 trig = 0;
    if (m_state == 1) m_state = 2;
  endtask

  // driver: build expected readout into the scoreboard
  task automatic push_expected();
    foreach (pre_hist[i]) exp_q.push_back(pre_hist[i]);
    foreach (post_q[i]) exp_q.push_back(post_q[i]);
  endtask

  task automatic read_n(input int n);
    @(posedge clk); #1 rd_req = 1;
    repeat (n) @(posedge clk);
    #1 rd_req = 0;
    @(posedge clk); #1;
  endtask

  task automatic check_no_more(input string req);
    @(posedge clk); #1 rd_req = 1;
    @(posedge clk); #1 rd_req = 0;
    @(negedge clk);
    chk(rd_valid == 0, req, int'(rd_valid), 0);
  endtask

  task automatic finish_capture(input int base, input string req_done);
    int need;
    need = DEPTH - m_pd - post_q.size();
    for (int i = 0; i < need; i++) begin
      if (i == need - 1) chk(done == 0, {req_done, " done early"}, int'(done), 0);
      wr(16'(base + i * 3), 0);
    end
    chk(done == 1, {req_done, " done after fill"}, int'(done), 1);
  endtask

  task automatic read_and_check(input string t);
    int n;
    push_expected();
    n = exp_q.size();
    tag = t;
    read_n(n);
    chk(exp_q.size() == 0, {t, " records left unread"}, exp_q.size(), 0);
    check_no_more("R9 read past end");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_state = 0; m_pd = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk(done == 0, "R1 reset done", int'(done), 0);
    chk(rd_valid == 0, "R1 reset valid", int'(rd_valid), 0);
    chk(trig_idx == 0, "R1 reset idx", int'(trig_idx), 0);

    // R1: writes and trigger before arm store nothing
    for (int i = 0; i < 5; i++) wr(16'hBEE0 + 16'(i), i == 2);
    chk(done == 0, "R1 pre-arm done", int'(done), 0);
    check_no_more("R10 read before done");

    // scenario A: code 5 (PD 32), trigger before ring fills (R5)
    do_arm(4'd5);
    for (int i = 0; i < 10; i++) wr(16'h1000 + 16'(i * 7), 0);
    trig_only();
    check_no_more("R10 read before done");
    finish_capture(16'h2000, "R6");
    chk(int'(trig_idx) == 10, "R7 idx partial ring", int'(trig_idx), 10);
    read_and_check("R5");

    // scenario B: code 3 (PD 19), wrap, write in trigger cycle, writes after done
    do_arm(4'd3);
    for (int i = 0; i < 50; i++) wr(16'h3000 + 16'(i), 0);
    wr(16'h4444, 1);
    finish_capture(16'h5000, "R6");
    chk(int'(trig_idx) == 19, "R3 idx code3", int'(trig_idx), 19);
    for (int i = 0; i < 4; i++) wr(16'hDEAD, i == 1);
    chk(done == 1, "R8 done held", int'(done), 1);
    chk(int'(trig_idx) == 19, "R8 idx held", int'(trig_idx), 19);
    read_and_check("R4");

    // scenario C: code 0 clamps to 1 (PD 6)
    do_arm(4'd0);
    for (int i = 0; i < 8; i++) wr(16'h6000 + 16'(i * 5), 0);
    trig_only();
    finish_capture(16'h6100, "R6");
    chk(int'(trig_idx) == 6, "R3 idx code0", int'(trig_idx), 6);
    read_and_check("R3");

    // scenario D: code 12 clamps to 9 (PD 57), long wrap
    do_arm(4'd12);
    for (int i = 0; i < 130; i++) wr(16'h7000 + 16'(i * 11), 0);
    trig_only();
    finish_capture(16'h7F00, "R6");
    chk(int'(trig_idx) == 57, "R3 idx code12", int'(trig_idx), 57);
    read_and_check("R2");

    // scenario E: trigger with no pre-trigger records, then re-arm mid readout
    do_arm(4'd9);
    trig_only();
    finish_capture(16'h8000, "R6");
    chk(int'(trig_idx) == 0, "R5 idx empty ring", int'(trig_idx), 0);
    push_expected();
    tag = "R5";
    read_n(3);
    chk(exp_q.size() == DEPTH - 57 - 3, "R9 partial read", exp_q.size(), DEPTH - 60);
    do_arm(4'd5);
    @(negedge clk);
    chk(done == 0, "R10 arm clears done", int'(done), 0);
    chk(trig_idx == 0, "R10 arm clears idx", int'(trig_idx), 0);
    check_no_more("R10 read after arm");
    for (int i = 0; i < 40; i++) wr(16'h9000 + 16'(i), 0);
    trig_only();
    finish_capture(16'h9A00, "R6");
    chk(int'(trig_idx) == 32, "R10 idx after re-arm", int'(trig_idx), 32);
    read_and_check("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule